// File: doc/BRIEF.md
# SDRAM bank command sequencer

This block turns one memory request at a time into a legal command stream for a double-data-rate SDRAM device. A request is a read or a write (bank, row, column, auto-precharge flag), a refresh, or a single mode-register write. The block keeps a table that holds, for each of the eight banks, whether a row is open and which row that is. From that table it decides whether the request can go straight to its column command, needs an activate first, or needs a precharge and then an activate.

Two counters shape the timing. A counter for each bank holds back column commands until the programmed activate-to-column delay has elapsed. A delay line marks the cycle when read data is due, a programmed CAS latency after the read command reaches the pins. All command pins are registered, and cycles with nothing to issue carry the no-operation encoding.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst` is high the pins show deselect (`mem_cs_n`=1, all strobes high) and `mem_cke`=0. From the first rising edge with `rst` low, `mem_cke` is 1 and stays 1.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n}: activate 0011, read 0101, write 0100, no-op 0111, burst stop 0110, precharge 0010, refresh 0001, mode write 0000. Any cycle with no command to issue shows 0111 with `mem_ba`=0 and `mem_addr`=0.
- R3: A read or write to a bank with no open row issues activate (`mem_ba`=bank, `mem_addr`=row), then its column command exactly max(`cfg_trcd`,1) cycles after the activate, with no-ops in between.
- R4: A request accepted at rising edge k shows its first command on the pins after edge k+1. A read or write to the open row of its bank goes straight to its column command.
- R5: A read or write to a bank whose open row differs issues precharge of that bank (`mem_addr[10]`=0, `mem_ba`=bank) in one cycle and activate of the new row in the next cycle. A bank never gets a second activate while it holds an open row.
- R6: Column commands carry the column on `mem_addr[COL_W-1:0]` and the auto-precharge flag on `mem_addr[10]`. After an auto-precharge access the bank counts as closed, so the next access to the same row starts with activate.
- R7: `rd_valid` is a one-cycle pulse exactly max(`cfg_cl`,1) cycles after each read command on the pins, and is 0 at all other times (including after writes).
- R8: A refresh with any bank open issues precharge-all (`mem_addr[10]`=1, `mem_ba`=0) then refresh in the next cycle. With all banks closed the refresh is issued at once.
- R9: A mode write closes any open banks the same way as R8, then issues the mode command with `mem_addr`=`req_row` and `mem_ba`=`req_bank`.
- R10: `req_ready` is 1 only when no request is in progress. It drops after acceptance and rises in the cycle that shows the request's last command. Request inputs that change while a request is in progress do not affect it.
- R11: After precharge-all, every bank counts as closed: the next read or write to any bank starts with activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block free to take a request |
| req_kind | input | 2 | 0 read, 1 write, 2 refresh, 3 mode write |
| req_bank | input | 3 | Target bank |
| req_row | input | ROW_W | Row, or mode value for a mode write |
| req_col | input | COL_W | Column |
| req_autopre | input | 1 | Close the bank after this access |
| cfg_trcd | input | DLY_W | Activate-to-column delay in cycles (0 acts as 1) |
| cfg_cl | input | DLY_W | Read latency in cycles (0 acts as 1) |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, low active |
| mem_ras_n | output | 1 | Row strobe, low active |
| mem_cas_n | output | 1 | Column strobe, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | ROW_W | Row / column / mode address; bit 10 carries the precharge scope |
| rd_valid | output | 1 | Read data due this cycle |

## Verification
On every cycle the bound checker keeps its own open-bank picture built only from the pins. It uses that picture to reject an activate to an open bank, a column command to a closed bank or one that comes before the delay has run out, and a refresh or mode write while any bank is open. It also rejects a `rd_valid` with no read behind it, and confirms that clock enable holds and that ready drops after acceptance. Exact command order, row and column placement on the address, the precise latency cycle of `rd_valid`, and the effect of auto-precharge on a later request can only be shown by the bench's directed and random request sequences. The bench compares each against a sequence it predicts from its own bank model.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_BST   = 4'b0110,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_e;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_WR  = 2'd1,
        REQ_REF = 2'd2,
        REQ_MRS = 2'd3
    } req_kind_e;

    // address bit that carries auto-precharge / precharge-all
    localparam int AP_BIT = 10;

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int BANKS = 8,
    parameter int ROW_W = 15
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        open_req,
    input  logic                        close_req,
    input  logic                        close_all,
    input  logic [$clog2(BANKS)-1:0]    sel,
    input  logic [ROW_W-1:0]            row,
    output logic [BANKS-1:0]            open_vec,
    output logic [BANKS-1:0][ROW_W-1:0] row_tab
);
    localparam int BA_W = $clog2(BANKS);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             is_open;
        logic [ROW_W-1:0] row_q;
        logic             hit;

        assign hit = (sel == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                is_open <= 1'b0;
                row_q   <= '0;
            end else if (close_all || (close_req && hit)) begin
                is_open <= 1'b0;
            end else if (open_req && hit) begin
                is_open <= 1'b1;
                row_q   <= row;
            end
        end

        assign open_vec[b] = is_open;
        assign row_tab[b]  = row_q;
    end
endmodule

// File: rtl/sdram_trcd_timer.sv
module sdram_trcd_timer #(
    parameter int BANKS = 8,
    parameter int DLY_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [$clog2(BANKS)-1:0] sel,
    input  logic [DLY_W-1:0]         cfg_trcd,
    output logic [BANKS-1:0]         ok
);
    localparam int BA_W = $clog2(BANKS);

    logic [DLY_W-1:0] load_val;
    // a delay of 0 is treated as 1: the counter then starts at zero
    assign load_val = cfg_trcd - DLY_W'(cfg_trcd != '0);

    for (genvar b = 0; b < BANKS; b++) begin : g_cnt
        logic [DLY_W-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (start && (sel == BA_W'(b))) begin
                cnt <= load_val;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign ok[b] = (cnt == '0);
    end
endmodule

// File: rtl/sdram_rd_latency.sv
module sdram_rd_latency #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_issue,
    input  logic [DLY_W-1:0] cfg_cl,
    output logic             rd_valid
);
    localparam int LAT_N = 1 << DLY_W;

    logic [LAT_N-1:0] taps;
    logic [DLY_W-1:0] cl_eff;

    assign cl_eff = (cfg_cl == '0) ? DLY_W'(1) : cfg_cl;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps <= {taps[LAT_N-2:0], rd_issue};
        end
    end

    assign rd_valid = taps[cl_eff];
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 15,
    parameter int COL_W = 10,
    parameter int BANKS = 8,
    parameter int DLY_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_kind,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     req_autopre,
    input  logic [DLY_W-1:0]         cfg_trcd,
    input  logic [DLY_W-1:0]         cfg_cl,
    output logic                     mem_cke,
    output logic                     mem_cs_n,
    output logic                     mem_ras_n,
    output logic                     mem_cas_n,
    output logic                     mem_we_n,
    output logic [$clog2(BANKS)-1:0] mem_ba,
    output logic [ROW_W-1:0]         mem_addr,
    output logic                     rd_valid
);
    localparam int BA_W = $clog2(BANKS);

    typedef struct packed {
        req_kind_e        kind;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ap;
    } req_t;

    req_t cur;
    logic busy;

    logic [BANKS-1:0]            open_vec;
    logic [BANKS-1:0][ROW_W-1:0] row_tab;
    logic [BANKS-1:0]            trcd_ok;

    cmd_e             nxt_cmd;
    logic [BA_W-1:0]  nxt_ba;
    logic [ROW_W-1:0] nxt_addr;
    logic             done;
    logic             tab_act, tab_close_one, tab_close_all;

    cmd_e             cmd_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q;
    logic             cke_q;

    // ---------------- command decision ----------------
    always_comb begin
        nxt_cmd       = CMD_NOP;
        nxt_ba        = '0;
        nxt_addr      = '0;
        done          = 1'b0;
        tab_act       = 1'b0;
        tab_close_one = 1'b0;
        tab_close_all = 1'b0;
        if (busy) begin
            case (cur.kind)
                REQ_RD, REQ_WR: begin
                    if (!open_vec[cur.bank]) begin
                        nxt_cmd  = CMD_ACT;
                        nxt_ba   = cur.bank;
                        nxt_addr = cur.row;
                        tab_act  = 1'b1;
                    end else if (row_tab[cur.bank] != cur.row) begin
                        nxt_cmd       = CMD_PRE;
                        nxt_ba        = cur.bank;
                        tab_close_one = 1'b1;
                    end else if (trcd_ok[cur.bank]) begin
                        nxt_cmd                = (cur.kind == REQ_RD) ? CMD_RD : CMD_WR;
                        nxt_ba                 = cur.bank;
                        nxt_addr[COL_W-1:0]    = cur.col;
                        nxt_addr[AP_BIT]       = cur.ap;
                        tab_close_one          = cur.ap;
                        done                   = 1'b1;
                    end
                end
                default: begin
                    if (|open_vec) begin
                        nxt_cmd          = CMD_PRE;
                        nxt_addr[AP_BIT] = 1'b1;
                        tab_close_all    = 1'b1;
                    end else if (cur.kind == REQ_REF) begin
                        nxt_cmd = CMD_REF;
                        done    = 1'b1;
                    end else begin
                        nxt_cmd  = CMD_MRS;
                        nxt_ba   = cur.bank;
                        nxt_addr = cur.row;
                        done     = 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- request holding and pin registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cur    <= '0;
            cke_q  <= 1'b0;
            cmd_q  <= CMD_DESEL;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            cke_q  <= 1'b1;
            cmd_q  <= nxt_cmd;
            ba_q   <= nxt_ba;
            addr_q <= nxt_addr;
            if (!busy && req_valid) begin
                busy     <= 1'b1;
                cur.kind <= req_kind_e'(req_kind);
                cur.bank <= req_bank;
                cur.row  <= req_row;
                cur.col  <= req_col;
                cur.ap   <= req_autopre;
            end else if (done) begin
                busy <= 1'b0;
            end
        end
    end

    assign req_ready = !busy;
    assign mem_cke   = cke_q;
    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
    assign mem_ba    = ba_q;
    assign mem_addr  = addr_q;

    // ---------------- sub-blocks ----------------
    sdram_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .open_req  (tab_act),
        .close_req (tab_close_one),
        .close_all (tab_close_all),
        .sel       (cur.bank),
        .row       (cur.row),
        .open_vec  (open_vec),
        .row_tab   (row_tab)
    );

    sdram_trcd_timer #(.BANKS(BANKS), .DLY_W(DLY_W)) u_trcd (
        .clk      (clk),
        .rst      (rst),
        .start    (tab_act),
        .sel      (cur.bank),
        .cfg_trcd (cfg_trcd),
        .ok       (trcd_ok)
    );

    sdram_rd_latency #(.DLY_W(DLY_W)) u_rdlat (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (nxt_cmd == CMD_RD),
        .cfg_cl   (cfg_cl),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 15,
    parameter int BANKS = 8,
    parameter int DLY_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [DLY_W-1:0]         cfg_trcd,
    input logic                     mem_cke,
    input logic                     mem_cs_n,
    input logic                     mem_ras_n,
    input logic                     mem_cas_n,
    input logic                     mem_we_n,
    input logic [$clog2(BANKS)-1:0] mem_ba,
    input logic [ROW_W-1:0]         mem_addr,
    input logic                     rd_valid
);
    localparam int AGE_MAX = (1 << (DLY_W + 1)) - 1;

    cmd_e pin_cmd;
    assign pin_cmd = cmd_e'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n});

    logic [DLY_W:0] trcd_eff;
    assign trcd_eff = (cfg_trcd == '0) ? (DLY_W + 1)'(1) : {1'b0, cfg_trcd};

    // open-bank picture rebuilt from the pins only
    logic [BANKS-1:0] seen_open;
    logic [DLY_W:0]   age [BANKS];
    logic [7:0]       rd_owed;

    for (genvar b = 0; b < BANKS; b++) begin : g_model
        always_ff @(posedge clk) begin
            if (rst) begin
                seen_open[b] <= 1'b0;
                age[b]       <= '0;
            end else begin
                if (pin_cmd == CMD_ACT && mem_ba == b) begin
                    seen_open[b] <= 1'b1;
                    age[b]       <= (DLY_W + 1)'(1);
                end else begin
                    if (age[b] != AGE_MAX[DLY_W:0]) age[b] <= age[b] + 1'b1;
                    if (pin_cmd == CMD_PRE && (mem_addr[AP_BIT] || mem_ba == b))
                        seen_open[b] <= 1'b0;
                    if (is_column(pin_cmd) && mem_addr[AP_BIT] && mem_ba == b)
                        seen_open[b] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_owed <= '0;
        else     rd_owed <= rd_owed + 8'(pin_cmd == CMD_RD) - 8'(rd_valid);
    end

    p_cke_held_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> mem_cke);

    p_selected_r2: assert property (@(posedge clk) disable iff (rst)
        mem_cke |-> !mem_cs_n);

    p_col_after_delay_r3: assert property (@(posedge clk) disable iff (rst)
        is_column(pin_cmd) |-> (seen_open[mem_ba] && age[mem_ba] >= trcd_eff));

    p_one_row_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_ACT) |-> !seen_open[mem_ba]);

    p_rdv_owed_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_owed != '0));

    p_ref_closed_r8: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_REF) |-> (seen_open == '0));

    p_mrs_closed_r9: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_MRS) |-> (seen_open == '0));

    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .ROW_W (ROW_W),
    .BANKS (BANKS),
    .DLY_W (DLY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_trcd  (cfg_trcd),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .rd_valid  (rd_valid)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
    import sdram_seq_pkg::*;

    localparam int ROW_W = 15;
    localparam int COL_W = 10;
    localparam int BANKS = 8;
    localparam int DLY_W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_kind = '0;
    logic [2:0]       req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_autopre = 1'b0;
    logic [DLY_W-1:0] cfg_trcd = 4'd2;
    logic [DLY_W-1:0] cfg_cl = 4'd3;
    logic             mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [2:0]       mem_ba;
    logic [ROW_W-1:0] mem_addr;
    logic             rd_valid;

    sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BANKS(BANKS), .DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
        .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
        .mem_addr(mem_addr), .rd_valid(rd_valid)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit               m_open [BANKS];
    logic [ROW_W-1:0] m_row  [BANKS];
    bit               m_flushed [BANKS];
    logic [63:0]      due = '0;

    function automatic logic [3:0] pins();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R7: expected read-valid pulses derived from observed read commands
    always @(negedge clk) begin
        if (rst) begin
            due = '0;
        end else begin
            due = due >> 1;
            if (due[0] || rd_valid) check("R7 rd_valid timing", 32'(rd_valid), 32'(due[0]));
            if (pins() == CMD_RD) due[(cfg_cl == 0) ? 1 : int'(cfg_cl)] = 1'b1;
        end
    end

    task automatic run_req(input int kind, input int bank, input logic [ROW_W-1:0] row,
                           input logic [COL_W-1:0] col, input bit ap);
        logic [3:0]       ec [16];
        logic [2:0]       eb [16];
        logic [ROW_W-1:0] ea [16];
        string            et [16];
        int n = 0;
        int teff = (cfg_trcd == 0) ? 1 : int'(cfg_trcd);
        bit any_open = 1'b0;
        for (int b = 0; b < BANKS; b++) any_open |= m_open[b];
        if (kind < 2) begin
            bit hit = m_open[bank] && (m_row[bank] == row);
            if (m_open[bank] && !hit) begin
                ec[n] = CMD_PRE; eb[n] = 3'(bank); ea[n] = '0; et[n] = "R5 miss precharge"; n++;
                m_open[bank] = 1'b0;
            end
            if (!m_open[bank]) begin
                ec[n] = CMD_ACT; eb[n] = 3'(bank); ea[n] = row;
                et[n] = m_flushed[bank] ? "R11 activate after precharge-all" : "R3 activate"; n++;
                for (int k = 0; k < teff - 1; k++) begin
                    ec[n] = CMD_NOP; eb[n] = '0; ea[n] = '0; et[n] = "R3 activate-to-column wait"; n++;
                end
                m_open[bank] = 1'b1; m_row[bank] = row; m_flushed[bank] = 1'b0;
            end
            ec[n] = (kind == 0) ? CMD_RD : CMD_WR; eb[n] = 3'(bank);
            ea[n] = ROW_W'(col) | (ROW_W'(ap) << AP_BIT);
            et[n] = ap ? "R6 auto-precharge column" : (hit ? "R4 row hit column" : "R3 column after activate");
            n++;
            if (ap) m_open[bank] = 1'b0;
        end else begin
            if (any_open) begin
                ec[n] = CMD_PRE; eb[n] = '0; ea[n] = ROW_W'(1) << AP_BIT;
                et[n] = (kind == 2) ? "R8 precharge-all" : "R9 precharge-all"; n++;
                for (int b = 0; b < BANKS; b++) begin m_open[b] = 1'b0; m_flushed[b] = 1'b1; end
            end
            if (kind == 2) begin
                ec[n] = CMD_REF; eb[n] = '0; ea[n] = '0; et[n] = "R8 refresh"; n++;
            end else begin
                ec[n] = CMD_MRS; eb[n] = 3'(bank); ea[n] = row; et[n] = "R9 mode write"; n++;
            end
        end

        @(negedge clk);
        check("R10 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_kind = 2'(kind); req_bank = 3'(bank);
        req_row = row; req_col = col; req_autopre = ap;
        @(negedge clk);
        req_valid = 1'b0;
        req_kind = 2'($urandom); req_bank = 3'($urandom);
        req_row = ROW_W'($urandom); req_col = COL_W'($urandom); req_autopre = 1'($urandom);
        check("R2 no-op while deciding", 32'(pins()), 32'(CMD_NOP));
        check("R10 ready low after accept", 32'(req_ready), 32'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({et[i], " cmd"}, 32'(pins()), 32'(ec[i]));
            check({et[i], " bank"}, 32'(mem_ba), 32'(eb[i]));
            check({et[i], " addr"}, 32'(mem_addr), 32'(ea[i]));
            check("R10 ready during request", 32'(req_ready), 32'(i == n - 1));
            check("R1 cke held", 32'(mem_cke), 32'd1);
        end
    endtask

    task automatic set_cfg(input int trcd, input int cl);
        repeat (20) @(negedge clk);
        cfg_trcd = 4'(trcd);
        cfg_cl = 4'(cl);
    endtask

    initial begin
        int unsigned seed_dummy;
        int trcd_tab [4] = '{2, 0, 5, 1};
        int cl_tab   [4] = '{3, 0, 4, 7};
        seed_dummy = $urandom(32'd2024);
        for (int b = 0; b < BANKS; b++) begin m_open[b] = 0; m_row[b] = '0; m_flushed[b] = 0; end

        repeat (3) @(negedge clk);
        check("R1 deselect in reset", 32'(pins()), 32'(CMD_DESEL));
        check("R1 cke low in reset", 32'(mem_cke), 32'd0);
        check("R7 no rd_valid in reset", 32'(rd_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cke after reset", 32'(mem_cke), 32'd1);
        check("R2 idle no-op", 32'(pins()), 32'(CMD_NOP));
        check("R2 idle addr", 32'(mem_addr), 32'd0);

        // directed corner cases
        run_req(0, 0, 15'd5, 10'h012, 1'b0);  // closed bank
        run_req(0, 0, 15'd5, 10'h3ff, 1'b0);  // row hit
        run_req(1, 0, 15'd9, 10'h001, 1'b0);  // row miss
        run_req(0, 0, 15'd9, 10'h020, 1'b1);  // auto-precharge
        run_req(0, 0, 15'd9, 10'h021, 1'b0);  // reopen after auto-precharge
        run_req(1, 3, 15'h7fff, 10'h155, 1'b0);
        run_req(2, 0, 15'd0, 10'd0, 1'b0);    // refresh with open banks
        run_req(2, 0, 15'd0, 10'd0, 1'b0);    // refresh all closed
        run_req(0, 3, 15'h7fff, 10'h002, 1'b0);
        run_req(3, 5, 15'h0433, 10'd0, 1'b0); // mode write with open bank
        run_req(0, 3, 15'h7fff, 10'h003, 1'b0);

        // constrained random in four timing settings
        for (int ph = 0; ph < 4; ph++) begin
            set_cfg(trcd_tab[ph], cl_tab[ph]);
            for (int i = 0; i < 45; i++) begin
                int r = int'($urandom_range(0, 19));
                int kind = (r < 9) ? 0 : (r < 17) ? 1 : (r < 19) ? 2 : 3;
                run_req(kind, int'($urandom_range(0, 7)), 15'($urandom_range(0, 3)),
                        10'($urandom), ($urandom_range(0, 3) == 0));
            end
        end

        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule